// File: doc/BRIEF.md
# Boot Window Command Sequencer

This block sits on the write path of a flash device's register space and decodes single-word commands written into the boot-buffer address window. It recognises four command codes: a soft reset, an identification fill, an arming code, and a trigger word that completes a two-write load handshake. For each one it issues a one-cycle request to the rest of the device. The page data transfer is done elsewhere. This block only supplies the request and its flat sector index.

The block also holds the block-address and page-address registers that a load uses. Each has its own write offset outside the boot window. A load request carries the flat sector index computed from these registers, and the page register then advances by four within an 8-bit range. Repeated arm/trigger pairs therefore walk through consecutive pages. An unknown code written while unarmed sets a sticky flag. The flag is cleared by a soft reset or by the external reset.

Top module: `boot_cmd_seq`

## Requirements
- R1: A boot command is decoded only from a write whose word address lies in 0x0000..0x01FF or 0x8000..0x800F. Writes to any other address leave the armed flag, the request outputs and the unknown flag unchanged.
- R2: Writing 0x00F0 to the window while unarmed raises soft_rst_o for exactly the following cycle. The same write clears the block and page registers and the unknown flag.
- R3: Writing 0x00E0 to the window while unarmed sets armed_o. The next window write clears armed_o whatever its value, and that write is not decoded as an ordinary command.
- R4: A window write of 0x0000 while armed raises load_req_o for one cycle. load_sector_o carries the sector index of the block and page registers as they stood before the write. An armed write of any other value raises no request and no flag.
- R5: With 2 KB pages (PAGE_2K=1) the sector index is (page & 3) + (((page >> 2) & 0x3F) + blk * 64) * 4. With 1 KB pages the final factor is 2.
- R6: The block number used in R5 is block bits 11:0, ORed with DENSITY_MASK when block bit 15 is set.
- R7: After each load the page register becomes (page + 4) mod 256, and its upper byte is cleared. For example, 0x00FE becomes 0x0002.
- R8: Writing 0x0090 while unarmed raises id_wr_o for one cycle. The three ID words become the low bytes of the manufacturer ID, the device ID and the write-protect status, each with its upper byte zero.
- R9: Any other value written to the window while unarmed sets unknown_cmd_o. The flag holds until a soft reset or rst_ni.
- R10: rst_ni low clears the armed flag, the block and page registers, the unknown flag, the ID words and all request pulses.
- R11: A write to 0xF100 loads the block register and a write to 0xF107 loads the page register. At most one of soft_rst_o, id_wr_o and load_req_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | ADDR_W | Word address of the write |
| wr_data_i | input | DATA_W | Write data |
| man_id_i | input | DATA_W | Manufacturer ID |
| dev_id_i | input | DATA_W | Device ID |
| wp_stat_i | input | DATA_W | Write-protect status |
| soft_rst_o | output | 1 | Soft reset request pulse |
| id_wr_o | output | 1 | ID fill request pulse |
| id_word0_o | output | DATA_W | Boot word 0 for the ID fill |
| id_word1_o | output | DATA_W | Boot word 1 for the ID fill |
| id_word2_o | output | DATA_W | Boot word 2 for the ID fill |
| load_req_o | output | 1 | Page load request pulse |
| load_sector_o | output | SecW | Sector index of the load |
| cur_blk_o | output | DATA_W | Current block register |
| cur_page_o | output | DATA_W | Current page register |
| armed_o | output | 1 | Load handshake armed |
| unknown_cmd_o | output | 1 | Sticky unknown-command flag |

## Verification
The bench builds the block with 2 KB pages and DENSITY_MASK set to 0x200. This makes the high-density path of the sector index observable: a block with bit 15 set yields a sector index that differs from its plain 12-bit block number. The default window bounds let the bench probe both edges of each range (0x01FF/0x0200 and 0x800F/0x8010). The 8-bit page field lets it drive the page register to 0xFE and observe the wrap after a single load.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  localparam logic [15:0] CODE_RESET = 16'h00F0;
  localparam logic [15:0] CODE_ARM   = 16'h00E0;
  localparam logic [15:0] CODE_IDENT = 16'h0090;
  localparam logic [15:0] CODE_LOAD  = 16'h0000;

  typedef enum logic [2:0] {
    BC_NONE, BC_RESET, BC_ARM, BC_IDENT, BC_LOAD, BC_OTHER
  } boot_cmd_e;
endpackage

// File: rtl/boot_win_decode.sv
module boot_win_decode #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 16,
  parameter logic [15:0] W0_LO   = 16'h0000,
  parameter logic [15:0] W0_HI   = 16'h01FF,
  parameter logic [15:0] W1_LO   = 16'h8000,
  parameter logic [15:0] W1_HI   = 16'h800F,
  parameter logic [15:0] BLK_REG = 16'hF100,
  parameter logic [15:0] PG_REG  = 16'hF107
) (
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [DATA_W-1:0]       wr_data_i,
  output logic                    win_hit_o,
  output logic                    blk_hit_o,
  output logic                    pg_hit_o,
  output boot_seq_pkg::boot_cmd_e cmd_o
);
  import boot_seq_pkg::*;

  logic in_w0, in_w1;

  // a zero lower bound needs no compare
  generate
    if (W0_LO == 16'h0000) begin : g_w0_base
      assign in_w0 = (wr_addr_i <= ADDR_W'(W0_HI));
    end else begin : g_w0_range
      assign in_w0 = (wr_addr_i >= ADDR_W'(W0_LO)) && (wr_addr_i <= ADDR_W'(W0_HI));
    end
    if (W1_LO == 16'h0000) begin : g_w1_base
      assign in_w1 = (wr_addr_i <= ADDR_W'(W1_HI));
    end else begin : g_w1_range
      assign in_w1 = (wr_addr_i >= ADDR_W'(W1_LO)) && (wr_addr_i <= ADDR_W'(W1_HI));
    end
  endgenerate

  assign win_hit_o = wr_en_i && (in_w0 || in_w1);
  assign blk_hit_o = wr_en_i && (wr_addr_i == ADDR_W'(BLK_REG));
  assign pg_hit_o  = wr_en_i && (wr_addr_i == ADDR_W'(PG_REG));

  always_comb begin
    cmd_o = BC_NONE;
    if (win_hit_o) begin
      if      (wr_data_i == DATA_W'(CODE_RESET)) cmd_o = BC_RESET;
      else if (wr_data_i == DATA_W'(CODE_ARM))   cmd_o = BC_ARM;
      else if (wr_data_i == DATA_W'(CODE_IDENT)) cmd_o = BC_IDENT;
      else if (wr_data_i == DATA_W'(CODE_LOAD))  cmd_o = BC_LOAD;
      else                                       cmd_o = BC_OTHER;
    end
  end
endmodule

// File: rtl/boot_addr_regs.sv
module boot_addr_regs #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned PG_W   = 8,
  parameter int unsigned STEP   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              blk_we_i,
  input  logic              pg_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              clr_i,
  input  logic              step_i,
  output logic [DATA_W-1:0] blk_o,
  output logic [DATA_W-1:0] page_o
);
  logic [PG_W-1:0] pg_next;
  assign pg_next = page_o[PG_W-1:0] + PG_W'(STEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_o  <= '0;
      page_o <= '0;
    end else if (clr_i) begin
      blk_o  <= '0;
      page_o <= '0;
    end else begin
      if (blk_we_i) blk_o <= wdata_i;
      if (step_i)        page_o <= DATA_W'(pg_next);
      else if (pg_we_i)  page_o <= wdata_i;
    end
  end
endmodule

// File: rtl/boot_sector_calc.sv
module boot_sector_calc #(
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned BLK_BITS     = 12,
  parameter int unsigned PG_SHIFT     = 2,
  parameter logic [11:0] DENSITY_MASK = 12'h000,
  localparam int unsigned SEC_W       = BLK_BITS + 6 + PG_SHIFT
) (
  input  logic [DATA_W-1:0] blk_i,
  input  logic [DATA_W-1:0] page_i,
  output logic [SEC_W-1:0]  sector_o
);
  logic [BLK_BITS-1:0] blk_eff;
  logic [BLK_BITS+5:0] pg_base;

  assign blk_eff  = blk_i[BLK_BITS-1:0] |
                    (blk_i[DATA_W-1] ? BLK_BITS'(DENSITY_MASK) : '0);
  assign pg_base  = {blk_eff, page_i[7:2]};
  assign sector_o = (SEC_W'(pg_base) << PG_SHIFT) + SEC_W'(page_i[1:0]);
endmodule

// File: rtl/boot_cmd_seq.sv
module boot_cmd_seq #(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned DATA_W       = 16,
  parameter bit          PAGE_2K      = 1'b1,
  parameter logic [11:0] DENSITY_MASK = 12'h000,
  localparam int unsigned PgShift     = PAGE_2K ? 2 : 1,
  localparam int unsigned SecW        = 12 + 6 + PgShift
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [DATA_W-1:0] man_id_i,
  input  logic [DATA_W-1:0] dev_id_i,
  input  logic [DATA_W-1:0] wp_stat_i,
  output logic              soft_rst_o,
  output logic              id_wr_o,
  output logic [DATA_W-1:0] id_word0_o,
  output logic [DATA_W-1:0] id_word1_o,
  output logic [DATA_W-1:0] id_word2_o,
  output logic              load_req_o,
  output logic [SecW-1:0]   load_sector_o,
  output logic [DATA_W-1:0] cur_blk_o,
  output logic [DATA_W-1:0] cur_page_o,
  output logic              armed_o,
  output logic              unknown_cmd_o
);
  import boot_seq_pkg::*;

  logic      win_hit_w, blk_hit_w, pg_hit_w;
  boot_cmd_e cmd_w;
  logic      do_load, do_reset;
  logic [SecW-1:0] sector_w;

  boot_win_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .win_hit_o (win_hit_w),
    .blk_hit_o (blk_hit_w),
    .pg_hit_o  (pg_hit_w),
    .cmd_o     (cmd_w)
  );

  // armed state consumes the window write whatever its code
  assign do_load  = armed_o && (cmd_w == BC_LOAD);
  assign do_reset = !armed_o && (cmd_w == BC_RESET);

  boot_addr_regs #(.DATA_W(DATA_W), .PG_W(8), .STEP(4)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .blk_we_i (blk_hit_w),
    .pg_we_i  (pg_hit_w),
    .wdata_i  (wr_data_i),
    .clr_i    (do_reset),
    .step_i   (do_load),
    .blk_o    (cur_blk_o),
    .page_o   (cur_page_o)
  );

  boot_sector_calc #(
    .DATA_W(DATA_W), .BLK_BITS(12), .PG_SHIFT(PgShift), .DENSITY_MASK(DENSITY_MASK)
  ) u_sec (
    .blk_i    (cur_blk_o),
    .page_i   (cur_page_o),
    .sector_o (sector_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_o       <= 1'b0;
      unknown_cmd_o <= 1'b0;
      soft_rst_o    <= 1'b0;
      id_wr_o       <= 1'b0;
      load_req_o    <= 1'b0;
      load_sector_o <= '0;
      id_word0_o    <= '0;
      id_word1_o    <= '0;
      id_word2_o    <= '0;
    end else begin
      soft_rst_o <= 1'b0;
      id_wr_o    <= 1'b0;
      load_req_o <= 1'b0;
      if (win_hit_w) begin
        if (armed_o) begin
          armed_o <= 1'b0;
          if (do_load) begin
            load_req_o    <= 1'b1;
            load_sector_o <= sector_w;
          end
        end else begin
          unique case (cmd_w)
            BC_RESET: begin
              soft_rst_o    <= 1'b1;
              unknown_cmd_o <= 1'b0;
            end
            BC_ARM:   armed_o <= 1'b1;
            BC_IDENT: begin
              id_wr_o    <= 1'b1;
              id_word0_o <= DATA_W'(man_id_i[7:0]);
              id_word1_o <= DATA_W'(dev_id_i[7:0]);
              id_word2_o <= DATA_W'(wp_stat_i[7:0]);
            end
            default:  unknown_cmd_o <= 1'b1;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/boot_cmd_seq_chk.sv
module boot_cmd_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       win_hit_w,
  input logic       armed_o,
  input logic       soft_rst_o,
  input logic       id_wr_o,
  input logic       load_req_o,
  input logic       unknown_cmd_o,
  input logic [15:0] cur_page_o
);
  // R4
  load_only_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_req_o |-> $past(armed_o));
  // R3
  arm_consumed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o && win_hit_w) |=> !armed_o);
  // R7
  page_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_req_o |-> (cur_page_o[7:0] == $past(cur_page_o[7:0]) + 8'd4) && (cur_page_o[15:8] == 8'h00));
  // R11
  one_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({soft_rst_o, id_wr_o, load_req_o}));
  // R9
  unknown_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(unknown_cmd_o) |-> soft_rst_o);
  // R2
  reset_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> !soft_rst_o);
endmodule

bind boot_cmd_seq boot_cmd_seq_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .win_hit_w     (win_hit_w),
  .armed_o       (armed_o),
  .soft_rst_o    (soft_rst_o),
  .id_wr_o       (id_wr_o),
  .load_req_o    (load_req_o),
  .unknown_cmd_o (unknown_cmd_o),
  .cur_page_o    (cur_page_o[15:0])
);

// File: tb/sim_boot_cmd_seq.sv
`timescale 1ns/1ps
module sim_boot_cmd_seq;
  localparam logic [11:0] DMASK = 12'h200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0, wr_data = '0;
  logic [15:0] man_id = 16'h12EC, dev_id = 16'h3440, wp_st = 16'h0502;
  logic        soft_rst, id_wr, load_req, armed, unk;
  logic [15:0] w0, w1, w2, cblk, cpg;
  logic [19:0] sector;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  boot_cmd_seq #(.DENSITY_MASK(DMASK)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .man_id_i(man_id), .dev_id_i(dev_id), .wp_stat_i(wp_st),
    .soft_rst_o(soft_rst), .id_wr_o(id_wr), .id_word0_o(w0), .id_word1_o(w1),
    .id_word2_o(w2), .load_req_o(load_req), .load_sector_o(sector),
    .cur_blk_o(cblk), .cur_page_o(cpg), .armed_o(armed), .unknown_cmd_o(unk)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] exp_sector(input logic [15:0] b, input logic [15:0] p);
    logic [11:0] be;
    be = b[11:0] | (b[15] ? DMASK : 12'h000);
    return 20'((p & 16'd3) + ((((p >> 2) & 16'h3F) + 32'(be) * 64) * 4));
  endfunction

  // outputs are sampled at the negedge after the capturing posedge
  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset_state;
    chk(!armed && !unk && !soft_rst && !id_wr && !load_req, "R10 reset flags",
        {armed, unk, soft_rst, id_wr, load_req}, 0);
    chk(cblk == 0 && cpg == 0, "R10 reset regs", {cblk, cpg}, 0);
  endtask

  task automatic t_load_basic;
    wr(16'hF100, 16'h0005);
    wr(16'hF107, 16'h000B);
    chk(cblk == 16'h0005 && cpg == 16'h000B, "R11 reg write", {cblk, cpg}, 32'h0005000B);
    wr(16'h0010, 16'h00E0);
    chk(armed, "R3 armed", armed, 1);
    wr(16'h0010, 16'h0000);
    chk(load_req, "R4 load pulse", load_req, 1);
    chk(sector == exp_sector(16'h0005, 16'h000B), "R5 sector", sector, exp_sector(16'h0005, 16'h000B));
    chk(cpg == 16'h000F, "R7 page step", cpg, 16'h000F);
    chk(!armed, "R3 armed cleared", armed, 0);
    @(negedge clk);
    chk(!load_req, "R4 single pulse", load_req, 0);
  endtask

  task automatic t_wrap;
    wr(16'hF107, 16'hA1FE);
    wr(16'h8000, 16'h00E0);
    wr(16'h8000, 16'h0000);
    chk(cpg == 16'h0002, "R7 wrap", cpg, 16'h0002);
    chk(sector == exp_sector(16'h0005, 16'hA1FE), "R5 sector upper page bits", sector,
        exp_sector(16'h0005, 16'hA1FE));
  endtask

  task automatic t_density;
    wr(16'hF100, 16'h8003);
    wr(16'hF107, 16'h0000);
    wr(16'h01FF, 16'h00E0);
    wr(16'h01FF, 16'h0000);
    chk(sector == exp_sector(16'h8003, 16'h0000) && sector == 20'd131840, "R6 density",
        sector, 20'd131840);
  endtask

  task automatic t_armed_other;
    wr(16'hF107, 16'h0020);
    wr(16'h0000, 16'h00E0);
    wr(16'h0000, 16'h0090);
    chk(!armed && !id_wr && !load_req && !unk, "R4 armed nonzero ignored",
        {armed, id_wr, load_req, unk}, 0);
    chk(cpg == 16'h0020, "R4 page kept", cpg, 16'h0020);
  endtask

  task automatic t_ident;
    wr(16'h800F, 16'h0090);
    chk(id_wr, "R8 pulse", id_wr, 1);
    chk(w0 == 16'h00EC && w1 == 16'h0040 && w2 == 16'h0002, "R8 words",
        {w0, w1, w2}, 48'h00EC_0040_0002);
  endtask

  task automatic t_window_edges;
    wr(16'h0200, 16'h00F0);
    chk(!soft_rst && cpg == 16'h0020, "R1 above low window", {soft_rst, cpg}, 16'h0020);
    wr(16'h8010, 16'h00E0);
    chk(!armed, "R1 above high window", armed, 0);
    wr(16'h7FFF, 16'h1234);
    chk(!unk, "R1 below high window", unk, 0);
    wr(16'h0100, 16'h00E0);
    wr(16'h4000, 16'h0000);
    chk(armed && !load_req, "R1 outside keeps armed", {armed, load_req}, 2'b10);
    wr(16'h0100, 16'h0000);
    chk(load_req, "R1 window load", load_req, 1);
  endtask

  task automatic t_unknown_and_soft;
    wr(16'h0001, 16'h0055);
    chk(unk, "R9 set", unk, 1);
    wr(16'h0002, 16'h0090);
    chk(unk, "R9 sticky", unk, 1);
    wr(16'hF100, 16'h0077);
    wr(16'h0003, 16'h00F0);
    chk(soft_rst, "R2 pulse", soft_rst, 1);
    chk(!unk && cblk == 0 && cpg == 0, "R2 clears", {unk, cblk, cpg}, 0);
    @(negedge clk);
    chk(!soft_rst, "R2 one cycle", soft_rst, 0);
  endtask

  task automatic t_rst_armed;
    wr(16'h0004, 16'h00E0);
    chk(armed, "R10 armed before", armed, 1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk(!armed, "R10 armed cleared", armed, 0);
    wr(16'h0004, 16'h0000);
    chk(!load_req && unk, "R10 trigger as command", {load_req, unk}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_load_basic();
    t_wrap();
    t_density();
    t_armed_other();
    t_ident();
    t_window_edges();
    t_unknown_and_soft();
    t_rst_armed();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule